// File: doc/BRIEF.md
# Region protection checker

This block decides, for every memory access, whether the access may proceed and which caching attributes apply. Instruction fetches and data accesses each have their own bank of eight address regions. A region is given as an aligned base address with a power-of-two size code and an enable flag. Per-region masks supply a cacheable bit, a bufferable bit (data side only) and a two-bit permission code. A request presents an address, a side select, a write flag and a privilege flag, and in the same cycle the block returns an abort flag and the cacheable and bufferable attributes of the region that governs that address.

Software fills the registers through a one-cycle write port. It selects a register kind, a side and a region index, and a write takes effect from the next clock edge. A control word holds the global protection enable together with the cache enables and a clock mode field. These are passed out for the surrounding logic to use. When several enabled regions cover an address, the highest-numbered one decides. Region 0 is therefore normally set up as a background that covers all memory with no access, and higher regions open windows in it.

Top module: `mpu_region_chk`

## Requirements
- R1: After reset every region is disabled, all cacheable, bufferable and permission bits are 0, and the control word is 0, so that ctl_prot_en, ctl_dcache_en, ctl_icache_en and ctl_clk_mode all read 0.
- R2: While protection is disabled, every request gives rsp_abort=0, rsp_cacheable=0 and rsp_bufferable=0, whatever the region contents.
- R3: A region word holds its base in bits 31:6, a size code N in bits 5:1 and an enable in bit 0. Base bits 5:0 are taken as zero. The region covers 2^(N+1) bytes and matches an address whose bits 31:N+1 equal those base bits. N=31 covers the whole 4 GB space.
- R4: A region with its enable bit clear never matches. With protection on, a request that matches no enabled region of its side aborts.
- R5: When several enabled regions of a side match, the one with the highest index decides the result.
- R6: Permission bits 2n+1:2n belong to region n. Code 00 aborts every request.
- R7: Code 01 aborts a request when req_priv is 0 and allows it when req_priv is 1.
- R8: Code 10 allows data reads and aborts data writes regardless of privilege.
- R9: Code 11 allows every request.
- R10: Instruction requests (req_instr=1) use only the instruction bank, the instruction cacheable mask and the instruction permissions. For them req_write has no effect and rsp_bufferable is always 0.
- R11: For an allowed request with protection on, rsp_cacheable is bit n of the side's cacheable mask and rsp_bufferable is bit n of the data bufferable mask, where n is the deciding region. An aborted request reports both attributes as 0.
- R12: A control write sets ctl_prot_en from bit 0, ctl_dcache_en from bit 2, ctl_icache_en from bit 12 and ctl_clk_mode from bits 31:30. The control word holds its value until the next control write.
- R13: cfg_sel selects 0 region word, 1 cacheable mask, 2 bufferable mask, 3 permission word, 4 control word. cfg_side selects 0 data or 1 instruction, and cfg_idx picks the region. A write is visible from the next rising edge. Selector values 5 to 7, and bufferable writes with cfg_side=1, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register kind selector |
| cfg_side | input | 1 | 0 data bank, 1 instruction bank |
| cfg_idx | input | 3 | Region index for region word writes |
| cfg_wdata | input | 32 | Write data |
| req_addr | input | 32 | Access address |
| req_instr | input | 1 | 1 instruction fetch, 0 data access |
| req_write | input | 1 | 1 write, 0 read |
| req_priv | input | 1 | 1 privileged request |
| rsp_abort | output | 1 | Access denied |
| rsp_cacheable | output | 1 | Deciding region is cacheable |
| rsp_bufferable | output | 1 | Deciding region is bufferable |
| ctl_prot_en | output | 1 | Protection enable from the control word |
| ctl_dcache_en | output | 1 | Data cache enable from the control word |
| ctl_icache_en | output | 1 | Instruction cache enable from the control word |
| ctl_clk_mode | output | 2 | Clock mode field from the control word |

## Verification
The hardest case to reach from the ports is a stack of overlapping enabled regions where a lower region allows an address and a higher, smaller region denies it. The edge addresses just inside and just outside each window must also be hit, including windows smaller than the 64-byte base granule. The stimulus builds such a nest on purpose: a 4 GB background, a 256 MB window, a 4 KB read-only window and an 8 KB privileged window inside it, and a 32-byte window inside a 16 KB window. It probes the first and last byte of each window and the byte just past it. A random phase follows that rewrites regions, masks and control words from a small pool of bases, so that overlaps keep recurring. It then compares against a behavioural model on every clock.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int BASE_LSB    = 6;
    localparam int SIZE_W      = 5;
    localparam int CTL_PROT    = 0;
    localparam int CTL_DCACHE  = 2;
    localparam int CTL_ICACHE  = 12;
    localparam int CTL_CLK_LSB = 30;
    localparam int NUM_SIDES   = 2;

    typedef enum logic [2:0] {
        SEL_REGION = 3'd0,
        SEL_CACHE  = 3'd1,
        SEL_BUFF   = 3'd2,
        SEL_PERM   = 3'd3,
        SEL_CTRL   = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_PRIV = 2'b01,
        PERM_RO   = 2'b10,
        PERM_FULL = 2'b11
    } perm_e;

    typedef struct packed {
        logic [ADDR_W-1:BASE_LSB] base;
        logic [SIZE_W-1:0]        size;
        logic                     en;
    } region_t;

    typedef struct packed {
        logic [1:0] clk_mode;
        logic       icache_en;
        logic       dcache_en;
        logic       prot_en;
    } ctrl_t;

    typedef struct packed {
        logic abort;
        logic cacheable;
        logic bufferable;
    } resp_t;

    // Address bits that take part in the compare for a size code.
    function automatic logic [ADDR_W-1:0] span_mask(input logic [SIZE_W-1:0] code);
        logic [SIZE_W:0] sh;
        sh = {1'b0, code} + 1'b1;
        return {ADDR_W{1'b1}} << sh;
    endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [2:0]                    cfg_sel,
    input  logic                          cfg_side,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output region_t [NUM_REGIONS-1:0]     regions_d,
    output region_t [NUM_REGIONS-1:0]     regions_i,
    output logic [NUM_REGIONS-1:0]        cache_d,
    output logic [NUM_REGIONS-1:0]        cache_i,
    output logic [NUM_REGIONS-1:0]        buff_d,
    output logic [2*NUM_REGIONS-1:0]      perm_d,
    output logic [2*NUM_REGIONS-1:0]      perm_i,
    output ctrl_t                         ctrl
);

    logic wr_region, wr_cache, wr_buff, wr_perm, wr_ctrl;

    always_comb begin
        wr_region = 1'b0;
        wr_cache  = 1'b0;
        wr_buff   = 1'b0;
        wr_perm   = 1'b0;
        wr_ctrl   = 1'b0;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_REGION: wr_region = 1'b1;
                SEL_CACHE:  wr_cache  = 1'b1;
                SEL_BUFF:   wr_buff   = !cfg_side;
                SEL_PERM:   wr_perm   = 1'b1;
                SEL_CTRL:   wr_ctrl   = 1'b1;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_t d_q, i_q;
        logic    hit_idx;

        assign hit_idx = wr_region && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                i_q <= '0;
            end else if (hit_idx) begin
                if (cfg_side) i_q <= region_t'(cfg_wdata);
                else          d_q <= region_t'(cfg_wdata);
            end
        end

        assign regions_d[g] = d_q;
        assign regions_i[g] = i_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_d <= '0;
            cache_i <= '0;
            buff_d  <= '0;
            perm_d  <= '0;
            perm_i  <= '0;
            ctrl    <= '0;
        end else begin
            if (wr_cache) begin
                if (cfg_side) cache_i <= cfg_wdata[NUM_REGIONS-1:0];
                else          cache_d <= cfg_wdata[NUM_REGIONS-1:0];
            end
            if (wr_buff) begin
                buff_d <= cfg_wdata[NUM_REGIONS-1:0];
            end
            if (wr_perm) begin
                if (cfg_side) perm_i <= cfg_wdata[2*NUM_REGIONS-1:0];
                else          perm_d <= cfg_wdata[2*NUM_REGIONS-1:0];
            end
            if (wr_ctrl) begin
                ctrl.clk_mode  <= cfg_wdata[CTL_CLK_LSB +: 2];
                ctrl.icache_en <= cfg_wdata[CTL_ICACHE];
                ctrl.dcache_en <= cfg_wdata[CTL_DCACHE];
                ctrl.prot_en   <= cfg_wdata[CTL_PROT];
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  region_t [NUM_REGIONS-1:0] regions,
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_REGIONS-1:0]    hit
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [ADDR_W-1:0] base_full;
        logic [ADDR_W-1:0] diff;

        assign base_full = {regions[g].base, {BASE_LSB{1'b0}}};
        assign diff      = (addr ^ base_full) & span_mask(regions[g].size);
        assign hit[g]    = regions[g].en && (diff == '0);
    end

endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic [NUM_REGIONS-1:0]   hit,
    input  logic [2*NUM_REGIONS-1:0] perm,
    input  logic [NUM_REGIONS-1:0]   cache,
    input  logic [NUM_REGIONS-1:0]   buff,
    input  logic                     prot_en,
    input  logic                     is_instr,
    input  logic                     is_write,
    input  logic                     is_priv,
    output resp_t                    resp
);

    logic             found;
    logic [IDX_W-1:0] win;
    perm_e            code;
    logic             deny;

    // Ascending scan: the last hit seen, i.e. the highest index, wins.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end

    assign code = perm_e'(perm[{win, 1'b0} +: 2]);

    always_comb begin
        case (code)
            PERM_NONE: deny = 1'b1;
            PERM_PRIV: deny = !is_priv;
            PERM_RO:   deny = is_write && !is_instr;
            default:   deny = 1'b0;
        endcase
    end

    always_comb begin
        if (!prot_en) begin
            resp = '0;
        end else if (!found || deny) begin
            resp = '{abort: 1'b1, cacheable: 1'b0, bufferable: 1'b0};
        end else begin
            resp = '{abort: 1'b0, cacheable: cache[win],
                     bufferable: buff[win] && !is_instr};
        end
    end

endmodule

// File: rtl/mpu_region_chk.sv
module mpu_region_chk
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic              cfg_side,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_instr,
    input  logic              req_write,
    input  logic              req_priv,
    output logic              rsp_abort,
    output logic              rsp_cacheable,
    output logic              rsp_bufferable,
    output logic              ctl_prot_en,
    output logic              ctl_dcache_en,
    output logic              ctl_icache_en,
    output logic [1:0]        ctl_clk_mode
);

    region_t [NUM_REGIONS-1:0]   regions_d, regions_i;
    logic [NUM_REGIONS-1:0]      cache_d, cache_i, buff_d;
    logic [2*NUM_REGIONS-1:0]    perm_d, perm_i;
    ctrl_t                       ctrl;

    region_t [NUM_REGIONS-1:0]   bank  [NUM_SIDES];
    logic [NUM_REGIONS-1:0]      hits  [NUM_SIDES];

    logic [NUM_REGIONS-1:0]      hit_sel, cache_sel, buff_sel;
    logic [2*NUM_REGIONS-1:0]    perm_sel;
    resp_t                       resp;

    mpu_cfg_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_side  (cfg_side),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .regions_d (regions_d),
        .regions_i (regions_i),
        .cache_d   (cache_d),
        .cache_i   (cache_i),
        .buff_d    (buff_d),
        .perm_d    (perm_d),
        .perm_i    (perm_i),
        .ctrl      (ctrl)
    );

    assign bank[0] = regions_d;
    assign bank[1] = regions_i;

    // One comparator bank per side; the side select is applied after compare.
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        mpu_region_match #(
            .NUM_REGIONS (NUM_REGIONS)
        ) u_match (
            .regions (bank[s]),
            .addr    (req_addr),
            .hit     (hits[s])
        );
    end

    assign hit_sel   = req_instr ? hits[1] : hits[0];
    assign cache_sel = req_instr ? cache_i : cache_d;
    assign perm_sel  = req_instr ? perm_i  : perm_d;
    assign buff_sel  = req_instr ? '0      : buff_d;

    mpu_prio_sel #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_sel (
        .hit      (hit_sel),
        .perm     (perm_sel),
        .cache    (cache_sel),
        .buff     (buff_sel),
        .prot_en  (ctrl.prot_en),
        .is_instr (req_instr),
        .is_write (req_write),
        .is_priv  (req_priv),
        .resp     (resp)
    );

    assign rsp_abort      = resp.abort;
    assign rsp_cacheable  = resp.cacheable;
    assign rsp_bufferable = resp.bufferable;
    assign ctl_prot_en    = ctrl.prot_en;
    assign ctl_dcache_en  = ctrl.dcache_en;
    assign ctl_icache_en  = ctrl.icache_en;
    assign ctl_clk_mode   = ctrl.clk_mode;

endmodule

// File: rtl/mpu_region_chk_sva.sv
module mpu_region_chk_sva #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [2:0]       cfg_sel,
    input logic             cfg_side,
    input logic [IDX_W-1:0] cfg_idx,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      req_addr,
    input logic             req_instr,
    input logic             req_write,
    input logic             req_priv,
    input logic             rsp_abort,
    input logic             rsp_cacheable,
    input logic             rsp_bufferable,
    input logic             ctl_prot_en,
    input logic             ctl_dcache_en,
    input logic             ctl_icache_en,
    input logic [1:0]       ctl_clk_mode
);

    logic ctl_write;
    assign ctl_write = cfg_we && (cfg_sel == 3'd4);

    // R2
    prot_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_prot_en |-> (!rsp_abort && !rsp_cacheable && !rsp_bufferable));

    // R10
    instr_no_buff_chk: assert property (@(posedge clk) disable iff (rst)
        req_instr |-> !rsp_bufferable);

    // R11
    abort_no_attr_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_abort |-> (!rsp_cacheable && !rsp_bufferable));

    // R12
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_write |=> (ctl_prot_en == $past(cfg_wdata[0]) &&
                       ctl_dcache_en == $past(cfg_wdata[2]) &&
                       ctl_icache_en == $past(cfg_wdata[12]) &&
                       ctl_clk_mode == $past(cfg_wdata[31:30])));

    // R12
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_write |=> ($stable(ctl_prot_en) && $stable(ctl_dcache_en) &&
                        $stable(ctl_icache_en) && $stable(ctl_clk_mode)));

endmodule

bind mpu_region_chk mpu_region_chk_sva #(.IDX_W(IDX_W)) u_sva (.*);

// File: tb/tb_mpu_region_chk.sv
`timescale 1ns/1ps
module tb_mpu_region_chk;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_side = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] req_addr = '0;
    logic        req_instr = 1'b0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic        rsp_abort, rsp_cacheable, rsp_bufferable;
    logic        ctl_prot_en, ctl_dcache_en, ctl_icache_en;
    logic [1:0]  ctl_clk_mode;

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    mpu_region_chk dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_side(cfg_side), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_addr(req_addr), .req_instr(req_instr), .req_write(req_write),
        .req_priv(req_priv), .rsp_abort(rsp_abort), .rsp_cacheable(rsp_cacheable),
        .rsp_bufferable(rsp_bufferable), .ctl_prot_en(ctl_prot_en),
        .ctl_dcache_en(ctl_dcache_en), .ctl_icache_en(ctl_icache_en),
        .ctl_clk_mode(ctl_clk_mode)
    );

    // Behavioural reference state
    logic [31:0] m_reg   [2][8];
    logic [7:0]  m_cache [2];
    logic [7:0]  m_buff;
    logic [15:0] m_perm  [2];
    logic [31:0] m_ctl;

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 8; i++) m_reg[s][i] = '0;
                m_cache[s] = '0;
                m_perm[s]  = '0;
            end
            m_buff = '0;
            m_ctl  = '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                3'd0: m_reg[cfg_side][cfg_idx] = cfg_wdata;
                3'd1: m_cache[cfg_side] = cfg_wdata[7:0];
                3'd2: if (!cfg_side) m_buff = cfg_wdata[7:0];
                3'd3: m_perm[cfg_side] = cfg_wdata[15:0];
                3'd4: m_ctl = cfg_wdata;
                default: ;
            endcase
        end
    end

    function automatic logic [2:0] model_lookup(logic [31:0] a, bit ins, bit wr, bit pv);
        int win = -1;
        int s = ins ? 1 : 0;
        logic [1:0] p;
        if (!m_ctl[0]) return 3'b000;
        for (int i = 0; i < 8; i++) begin
            longint unsigned sh = 64'(m_reg[s][i][5:1]) + 1;
            longint unsigned av = {32'd0, a};
            longint unsigned bv = {32'd0, m_reg[s][i][31:6], 6'd0};
            if (m_reg[s][i][0] && ((av >> sh) == (bv >> sh))) win = i;
        end
        if (win < 0) return 3'b100;
        p = m_perm[s][2*win +: 2];
        if (p == 2'b00 || (p == 2'b01 && !pv) || (p == 2'b10 && wr && !ins))
            return 3'b100;
        return {1'b0, m_cache[s][win], ins ? 1'b0 : m_buff[win]};
    endfunction

    // Per-clock comparison against the model, well after inputs move.
    always @(negedge clk) begin
        #2;
        if (!done) begin
            logic [2:0] e, act;
            logic [4:0] ec, ac;
            e   = model_lookup(req_addr, req_instr, req_write, req_priv);
            act = {rsp_abort, rsp_cacheable, rsp_bufferable};
            checks++;
            if (act !== e) begin
                failures++;
                $display("FAIL %s addr=%h resp actual=%b expected=%b", cur_tag, req_addr, act, e);
            end
            ec = {m_ctl[31:30], m_ctl[12], m_ctl[2], m_ctl[0]};
            ac = {ctl_clk_mode, ctl_icache_en, ctl_dcache_en, ctl_prot_en};
            checks++;
            if (ac !== ec) begin
                failures++;
                $display("FAIL R12 ctl actual=%b expected=%b", ac, ec);
            end
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input bit side,
                             input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_side = side; cfg_idx = idx; cfg_wdata = d;
        cur_tag = "R13";
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input bit ins, input bit wr,
                          input bit pv, input logic [2:0] exp3, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        req_addr = a; req_instr = ins; req_write = wr; req_priv = pv;
        cur_tag = tag;
        #1;
        checks++;
        if ({rsp_abort, rsp_cacheable, rsp_bufferable} !== exp3) begin
            failures++;
            $display("FAIL %s addr=%h actual=%b expected=%b", tag, a,
                     {rsp_abort, rsp_cacheable, rsp_bufferable}, exp3);
        end
    endtask

    task automatic check_ctl(input logic [4:0] exp5, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if ({ctl_clk_mode, ctl_icache_en, ctl_dcache_en, ctl_prot_en} !== exp5) begin
            failures++;
            $display("FAIL %s ctl actual=%b expected=%b", tag,
                     {ctl_clk_mode, ctl_icache_en, ctl_dcache_en, ctl_prot_en}, exp5);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [31:0] POOL [8] = '{32'h0000_0000, 32'h0000_0040, 32'h1000_0000,
        32'h1000_2000, 32'h2400_0000, 32'h8000_0000, 32'hFFFF_FFC0, 32'h1000_0800};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check_ctl(5'b00000, "R1");
        access(32'h0000_0000, 1'b0, 1'b1, 1'b0, 3'b000, "R1");

        // Data bank: background, 16 KB, 32 MB, 256 MB windows
        cfg_write(3'd0, 1'b0, 3'd0, 32'h0000_003F);
        cfg_write(3'd0, 1'b0, 3'd1, 32'h0000_001B);
        cfg_write(3'd0, 1'b0, 3'd2, 32'h2400_0031);
        cfg_write(3'd0, 1'b0, 3'd3, 32'h1000_0037);
        cfg_write(3'd0, 1'b1, 3'd0, 32'h0000_003F);
        cfg_write(3'd0, 1'b1, 3'd1, 32'h0000_001B);
        cfg_write(3'd0, 1'b1, 3'd2, 32'h2400_0031);
        cfg_write(3'd1, 1'b0, 3'd0, 32'h0000_0006);
        cfg_write(3'd2, 1'b0, 3'd0, 32'h0000_0006);
        cfg_write(3'd1, 1'b1, 3'd0, 32'h0000_0006);
        cfg_write(3'd3, 1'b0, 3'd0, 32'h0000_00FC);
        cfg_write(3'd3, 1'b1, 3'd0, 32'h0000_00FC);
        // R2: regions set but protection still off
        access(32'h4000_0000, 1'b0, 1'b1, 1'b0, 3'b000, "R2");
        cfg_write(3'd4, 1'b0, 3'd0, 32'hC000_1005);
        check_ctl(5'b11111, "R12");

        access(32'h0000_0100, 1'b0, 1'b0, 1'b1, 3'b011, "R11");
        access(32'h0000_3FFF, 1'b0, 1'b0, 1'b1, 3'b011, "R3");
        access(32'h0000_4000, 1'b0, 1'b0, 1'b1, 3'b100, "R6");
        access(32'h25FF_FFFF, 1'b0, 1'b1, 1'b0, 3'b011, "R3");
        access(32'h2600_0000, 1'b0, 1'b0, 1'b1, 3'b100, "R3");
        access(32'h1000_0000, 1'b0, 1'b1, 1'b0, 3'b000, "R9");
        access(32'h1000_0000, 1'b1, 1'b0, 1'b1, 3'b100, "R10");
        access(32'h2400_0010, 1'b1, 1'b1, 1'b0, 3'b010, "R10");

        // Nested windows: region 4 read-only 4 KB, region 5 privileged 8 KB,
        // region 7 disabled, region 6 a 32-byte no-access hole
        cfg_write(3'd0, 1'b0, 3'd4, 32'h1000_0017);
        cfg_write(3'd0, 1'b0, 3'd5, 32'h1000_2019);
        cfg_write(3'd0, 1'b0, 3'd7, 32'h1000_0036);
        cfg_write(3'd1, 1'b0, 3'd0, 32'h0000_0016);
        cfg_write(3'd3, 1'b0, 3'd0, 32'h0000_C6FC);
        access(32'h1000_0800, 1'b0, 1'b0, 1'b0, 3'b010, "R8");
        access(32'h1000_0800, 1'b0, 1'b1, 1'b1, 3'b100, "R8");
        access(32'h1000_1000, 1'b0, 1'b1, 1'b0, 3'b000, "R5");
        access(32'h1000_3FFF, 1'b0, 1'b0, 1'b0, 3'b100, "R7");
        access(32'h1000_2000, 1'b0, 1'b1, 1'b1, 3'b000, "R7");
        access(32'h1000_0FFF, 1'b0, 1'b0, 1'b1, 3'b010, "R4");
        cfg_write(3'd0, 1'b0, 3'd6, 32'h0000_0049);
        access(32'h0000_0050, 1'b0, 1'b0, 1'b1, 3'b100, "R3");
        access(32'h0000_0060, 1'b0, 1'b0, 1'b1, 3'b011, "R3");
        cfg_write(3'd0, 1'b0, 3'd0, 32'h0000_0000);
        access(32'h8000_0000, 1'b0, 1'b0, 1'b1, 3'b100, "R4");

        // R13: ignored writes
        cfg_write(3'd2, 1'b1, 3'd0, 32'h0000_0000);
        access(32'h0000_0100, 1'b0, 1'b0, 1'b1, 3'b011, "R13");
        cfg_write(3'd5, 1'b0, 3'd1, 32'h0000_0000);
        cfg_write(3'd7, 1'b1, 3'd1, 32'h0000_0000);
        access(32'h0000_0100, 1'b0, 1'b0, 1'b1, 3'b011, "R13");
        check_ctl(5'b11111, "R13");

        // R2 and R12: protection off again
        cfg_write(3'd4, 1'b0, 3'd0, 32'h4000_0004);
        check_ctl(5'b01010, "R12");
        access(32'h8000_0000, 1'b0, 1'b1, 1'b0, 3'b000, "R2");
        cfg_write(3'd4, 1'b0, 3'd0, 32'h0000_0001);

        // Random phase, compared each clock by the monitor
        for (int n = 0; n < 1500; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0) begin
                logic [2:0] sel;
                logic [31:0] d;
                sel = 3'($urandom_range(0, 7));
                d = $urandom;
                if (sel == 3'd0)
                    d = (POOL[$urandom_range(0, 7)] & 32'hFFFF_FFC0) | {26'd0, d[5:0]};
                if (sel == 3'd4) d[0] = ($urandom_range(0, 5) != 0);
                cfg_we = 1'b1; cfg_sel = sel; cfg_side = 1'($urandom);
                cfg_idx = 3'($urandom); cfg_wdata = d;
                cur_tag = "R13";
            end else begin
                cfg_we = 1'b0;
                cur_tag = "R5";
            end
            req_addr  = ($urandom_range(0, 3) == 0) ? $urandom
                        : POOL[$urandom_range(0, 7)] + 32'($urandom_range(0, 8191));
            req_instr = 1'($urandom);
            req_write = 1'($urandom);
            req_priv  = 1'($urandom);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        #3 done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule